// File: doc/BRIEF.md
# Fractional Baud-Rate Generator

This block turns a peripheral clock into single-cycle baud tick pulses for a serial channel. It never generates a clock. Every stage produces a clock-enable pulse, and all logic runs in one clock domain.

The pulses pass through three stages in order:
- a power-of-two prescaler;
- an optional 256-step phase-accumulator fractional divider;
- an 8-bit count-down timer that reloads on underflow.

The fractional stage adds a step value to an 8-bit accumulator on every prescaler pulse. The carry out of that addition is the stage's output pulse, so the average rate is step/256 of the prescaler rate.

Two controls act on the timer. A run input starts and stops it. Enabling the fractional divider while the divider-mode select is set to normal mode halts the timer whatever the run input is. A registered copy of the fractional carry is also brought out, so the fractional stage can be observed on its own.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset (rstN low) is asserted, baudTick and fracOvf are 0, and the prescaler counter, the accumulator and the timer are cleared. The first timer enable after reset loads reloadVal and gives no tick.
- R2: The prescaler gives one enable pulse every 2^preExp clocks, for preExp from 0 to 7. With preExp = 0 it pulses on every clock.
- R3: In fractional mode (fracEn = 1, modeNormal = 0):
  - each prescaler pulse adds stepVal to an 8-bit accumulator that wraps modulo 256;
  - a carry out of bit 7 is the timer enable for that clock;
  - fracOvf is high for exactly the one clock after that edge.
- R4: With fracEn = 1 and stepVal = 0, fracOvf never rises and the timer never advances.
- R5: The timer counts down by one on each enable. On an enable at value 0 it reloads from reloadVal. baudTick is then high for one clock, in the clock after that edge. A full period is reloadVal + 1 enables, so reloadVal = 0 ticks on every enable.
- R6: While runEn is 0, the timer holds its value and no tick is produced. When runEn returns to 1, counting resumes from the held value.
- R7: With fracEn = 1 and modeNormal = 1, the timer is halted whatever runEn is, and neither baudTick nor fracOvf pulses.
- R8: With fracEn = 0, the timer advances on each prescaler pulse while runEn is 1.
- R9: Over a long window, the tick count is clocks / 2^preExp × S / (reloadVal + 1), give or take one tick. S is stepVal/256 in fractional mode and 1 with fracEn = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Timer run control |
| preExp | input | 3 | Prescale exponent N; divide by 2^N |
| fracEn | input | 1 | Fractional divider enable |
| modeNormal | input | 1 | Divider-mode select: 1 = normal (halts the timer when fracEn is 1), 0 = fractional |
| stepVal | input | 8 | Fractional step added per prescaler pulse |
| reloadVal | input | 8 | Timer reload value |
| baudTick | output | 1 | One-clock baud tick |
| fracOvf | output | 1 | Registered fractional carry pulse |

## Verification
The assertions rely on the outputs being registered: each pulse reflects the control inputs of the clock before it. They therefore assume that the run, mode and step inputs hold steady across the edge that produces a pulse. The stimulus respects this by changing the inputs only on the falling edge. A behavioural reference model, updated on the rising edge from those settled inputs, predicts both outputs for every clock. Long windows at fixed settings then compare the tick rate against the closed-form rate. The stimulus also moves between modes, stops the timer and restarts it in the middle of a period.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic accStep;   // advance the fractional accumulator
    logic preStep;   // timer enable taken straight from the prescaler
    logic fracGate;  // timer may advance on a fractional carry
  } baudStrobe_t;

endpackage

// File: rtl/baud_gen_ctrl.sv
module baud_gen_ctrl
  import baud_gen_pkg::*;
#(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [EXP_W-1:0] preExp,
  input  logic             fracEn,
  input  logic             modeNormal,
  output baudStrobe_t      strobe
);

  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] preMask;
  logic             preTick;
  logic             fracMode;
  logic             haltTimer;
  logic             runOk;

  // Free-running prescaler counter; a pulse when its low N bits are all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    preMask   = ~({CNT_W{1'b1}} << preExp);
    preTick   = ((preCnt & preMask) == preMask);
    fracMode  = fracEn & ~modeNormal;
    haltTimer = fracEn & modeNormal;
    runOk     = runEn & ~haltTimer;

    strobe.accStep  = preTick & fracMode;
    strobe.preStep  = preTick & ~fracEn & runOk;
    strobe.fracGate = fracMode & runOk;
  end

endmodule

// File: rtl/baud_gen_datapath.sv
module baud_gen_datapath
  import baud_gen_pkg::*;
#(
  parameter int ACC_W = 8,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  baudStrobe_t      strobe,
  input  logic [ACC_W-1:0] stepVal,
  input  logic [TMR_W-1:0] reloadVal,
  output logic             baudTick,
  output logic             fracOvf
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   accSum;
  logic             fracCarry;
  logic             timerEn;
  logic [TMR_W-1:0] tmr;
  logic             loaded;

  always_comb begin
    accSum    = {1'b0, acc} + {1'b0, stepVal};
    fracCarry = strobe.accStep & accSum[ACC_W];
    timerEn   = strobe.preStep | (strobe.fracGate & fracCarry);
  end

  // Fractional phase accumulator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      fracOvf <= 1'b0;
    end else begin
      if (strobe.accStep) acc <= accSum[ACC_W-1:0];
      fracOvf <= fracCarry;
    end
  end

  // Count-down reload timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr      <= '0;
      loaded   <= 1'b0;
      baudTick <= 1'b0;
    end else begin
      baudTick <= 1'b0;
      if (timerEn) begin
        if (!loaded) begin
          tmr    <= reloadVal;
          loaded <= 1'b1;
        end else if (tmr == '0) begin
          tmr      <= reloadVal;
          baudTick <= 1'b1;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_gen_pkg::*;
#(
  parameter int EXP_W = 3,
  parameter int ACC_W = 8,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [EXP_W-1:0] preExp,
  input  logic             fracEn,
  input  logic             modeNormal,
  input  logic [ACC_W-1:0] stepVal,
  input  logic [TMR_W-1:0] reloadVal,
  output logic             baudTick,
  output logic             fracOvf
);

  baudStrobe_t strobe;

  baud_gen_ctrl #(.EXP_W(EXP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .preExp(preExp),
    .fracEn(fracEn), .modeNormal(modeNormal), .strobe(strobe)
  );

  baud_gen_datapath #(.ACC_W(ACC_W), .TMR_W(TMR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepVal(stepVal),
    .reloadVal(reloadVal), .baudTick(baudTick), .fracOvf(fracOvf)
  );

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int ACC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             fracEn,
  input logic             modeNormal,
  input logic [ACC_W-1:0] stepVal,
  input logic             baudTick,
  input logic             fracOvf
);

  // Timer halted by the mode combination
  assert_halt_no_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fracEn && modeNormal) |=> (!baudTick && !fracOvf));

  // Stopped timer never ticks
  assert_stop_no_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !baudTick);

  // Zero step never carries
  assert_zero_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fracEn && stepVal == '0) |=> !fracOvf);

  // Carry pulse only exists in fractional mode
  assert_ovf_frac_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(fracEn && !modeNormal) |=> !fracOvf);

  // In fractional mode a tick needs a carry in the same clock
  assert_tick_needs_carry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fracEn && !modeNormal) |=> (!baudTick || fracOvf));

endmodule

bind frac_baud_gen frac_baud_gen_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .fracEn(fracEn),
  .modeNormal(modeNormal), .stepVal(stepVal),
  .baudTick(baudTick), .fracOvf(fracOvf)
);

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0;
  logic [2:0] preExp = '0;
  logic       fracEn = 1'b0;
  logic       modeNormal = 1'b0;
  logic [7:0] stepVal = '0;
  logic [7:0] reloadVal = '0;
  logic       baudTick;
  logic       fracOvf;

  int compared = 0;
  int mismatched = 0;
  int totalTicks = 0;
  int totalOvf = 0;
  bit checkOn = 1'b0;
  bit done = 1'b0;
  string curReq = "R1";

  // Reference model state
  int  mPre = 0, mAcc = 0, mTmr = 0;
  bit  mLoaded = 0, expTick = 0, expOvf = 0;

  always #2.5 clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .preExp(preExp),
    .fracEn(fracEn), .modeNormal(modeNormal), .stepVal(stepVal),
    .reloadVal(reloadVal), .baudTick(baudTick), .fracOvf(fracOvf)
  );

  // Behavioural model, updated from the inputs settled before the edge
  always @(posedge clk) begin
    if (!rstN) begin
      mPre = 0; mAcc = 0; mTmr = 0; mLoaded = 0; expTick = 0; expOvf = 0;
    end else begin
      int  div;
      bit  pre, carry, en;
      div   = 1 << preExp;
      pre   = ((mPre % div) == div - 1);
      mPre  = (mPre + 1) % 128;
      carry = 0;
      if (pre && fracEn && !modeNormal) begin
        carry = (mAcc + stepVal) >= 256;
        mAcc  = (mAcc + stepVal) % 256;
      end
      expOvf  = carry;
      en      = runEn && !(fracEn && modeNormal) && (fracEn ? carry : pre);
      expTick = 0;
      if (en) begin
        if (!mLoaded) begin mTmr = reloadVal; mLoaded = 1; end
        else if (mTmr == 0) begin expTick = 1; mTmr = reloadVal; end
        else mTmr = mTmr - 1;
      end
    end
  end

  // Per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (baudTick) totalTicks++;
    if (fracOvf)  totalOvf++;
    if (checkOn) begin
      compared++;
      if (baudTick !== expTick || fracOvf !== expOvf) begin
        mismatched++;
        $display("FAIL %s: tick/ovf actual %b/%b expected %b/%b at %0t",
                 curReq, baudTick, fracOvf, expTick, expOvf, $time);
      end
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int actual, input int expected, input int tol);
    compared++;
    if (actual > expected + tol || actual < expected - tol) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic windowCheck(input string req, input int cycles, input int expected);
    int startT;
    waitCycles(40);
    #1 startT = totalTicks;
    waitCycles(cycles);
    #1 check(req, totalTicks - startT, expected, 1);
  endtask

  task automatic setMode(input bit run, input int exp, input bit fe, input bit mn,
                         input int step, input int rel);
    @(negedge clk);
    runEn = run; preExp = 3'(exp); fracEn = fe; modeNormal = mn;
    stepVal = 8'(step); reloadVal = 8'(rel);
  endtask

  initial begin
    int startT, startO;
    waitCycles(3);
    curReq = "R1";
    check("R1 reset tick", baudTick, 0, 0);
    check("R1 reset ovf", fracOvf, 0, 0);
    checkOn = 1'b1;
    // R1/R8: first enable after reset loads, tick comes one period later
    runEn = 1; preExp = 0; reloadVal = 8'd2;
    @(negedge clk); rstN = 1'b1;
    waitCycles(20);

    // R2 / R8 / R9: prescaler path
    curReq = "R8";
    setMode(1, 0, 0, 0, 0, 3);
    windowCheck("R8 div1 reload3", 400, 100);
    curReq = "R2";
    setMode(1, 2, 0, 0, 0, 0);
    windowCheck("R2 div4 reload0", 400, 100);
    setMode(1, 7, 0, 0, 0, 0);
    windowCheck("R2 div128", 1280, 10);

    // R3 / R5 / R9: fractional path
    curReq = "R3";
    setMode(1, 0, 1, 0, 64, 1);
    windowCheck("R9 step64 reload1", 800, 100);
    #1 startO = totalOvf;
    waitCycles(400);
    #1 check("R3 carry rate", totalOvf - startO, 100, 1);
    setMode(1, 1, 1, 0, 96, 2);
    windowCheck("R9 step96 div2 reload2", 1600, 100);
    curReq = "R5";
    setMode(1, 0, 1, 0, 255, 0);
    windowCheck("R5 reload0 step255", 512, 510);

    // R4: zero step
    curReq = "R4";
    setMode(1, 0, 1, 0, 0, 0);
    waitCycles(2);
    #1 startT = totalTicks; startO = totalOvf;
    waitCycles(300);
    #1 check("R4 no ticks", totalTicks - startT, 0, 0);
    check("R4 no carry", totalOvf - startO, 0, 0);

    // R7: halt combination overrides run
    curReq = "R7";
    setMode(1, 0, 1, 1, 128, 0);
    waitCycles(2);
    #1 startT = totalTicks; startO = totalOvf;
    waitCycles(300);
    #1 check("R7 halted ticks", totalTicks - startT, 0, 0);
    check("R7 halted carry", totalOvf - startO, 0, 0);

    // R6: freeze mid-period, then resume from the held value
    curReq = "R6";
    setMode(1, 0, 0, 0, 0, 9);
    waitCycles(25);
    setMode(0, 0, 0, 0, 0, 9);
    waitCycles(2);
    #1 startT = totalTicks;
    waitCycles(200);
    #1 check("R6 stopped ticks", totalTicks - startT, 0, 0);
    setMode(1, 0, 0, 0, 0, 9);
    windowCheck("R6 resumed rate", 500, 50);

    checkOn = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule